// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block sits on a simple processor bus and gives software three byte-wide parallel ports: A, B and C. A control register picks the direction of port A, port B, and the low and high nibbles of port C, each on its own. Outputs hold the value that was last written to them. Inputs return the live pin level whenever they are read. Only plain input/output operation is supported.

Bus writes are synchronous. A write takes place on the rising clock edge where the select and write strobes are both high. Reads are combinational: the read data is valid in the same cycle that the select and read strobes are high, and it is zero at all other times. Each port drives its latched value on its output pins all the time. A per-pin enable tells the pad whether to drive. Software changes a port's direction by writing a new mode word. Every mode write also clears all output latches.

Top module: `pario3`

## Requirements
- R1: The address selects the register: 0 is port A, 1 is port B, 2 is port C, and 3 is the control register.
- R2: After reset, every pin enable is 0, every output latch is 0, and a read of the control register returns 8'h9B.
- R3: A control write with bit 7 = 1 sets the directions, where 1 means input. Bit 4 sets port A, bit 1 sets port B, bit 3 sets the C high nibble (bits 7..4) and bit 0 sets the C low nibble (bits 3..0). A pin's enable is 1 only when its port or nibble is an output.
- R4: A control write with bit 7 = 1 clears the A, B and C output latches to zero on the next clock edge.
- R5: A control write with bit 7 = 0 has no effect on the directions, the latches or the control readback.
- R6: A write to port A, B or C loads that port's latch on the clock edge. With no write, all latches and enables hold their values.
- R7: A read of port A or port B while it is set as input returns its live pin value in the same cycle.
- R8: A read of port A or port B while it is set as output returns its latch.
- R9: A read of port C returns, for each nibble, the latch if that nibble is an output and the pins if it is an input.
- R10: A read of the control register returns {1, 0, 0, A dir, C-high dir, 0, B dir, C-low dir}, which equals the last accepted mode word ANDed with 8'h9B.
- R11: The read data is zero whenever select or read is low.
- R12: A write strobe while select is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| addr | input | 2 | Register offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A drive enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B drive enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C drive enable |

## Verification
The only state is three latches and four direction bits, and all of them reach the pins within one clock edge. A wrong direction bit shows up as a wrong enable, and also as a mismatch between pin and latch in the very next read. A latch that failed to clear or failed to load appears on its output pins right after the edge that should have changed it. Each vector therefore uses latch values that differ from the pin values, so that every read shows which source the data came from.

// File: rtl/pario3.sv
module pario3 #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [1:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] dout,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  localparam int HW = PW / 2;

  logic a_in, b_in, cu_in, cl_in;
  logic [PW-1:0] a_q, b_q, c_q;
  logic wen, mode_wr;

  assign wen     = sel && wr;
  assign mode_wr = wen && addr == 2'd3 && din[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {a_in, b_in, cu_in, cl_in} <= 4'hF;
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (mode_wr) begin
      a_in  <= din[4];
      b_in  <= din[1];
      cu_in <= din[3];
      cl_in <= din[0];
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
    end else if (wen) begin
      case (addr)
        2'd0:    a_q <= din;
        2'd1:    b_q <= din;
        2'd2:    c_q <= din;
        default: ;
      endcase
    end
  end

  assign pa_out = a_q;
  assign pb_out = b_q;
  assign pc_out = c_q;
  assign pa_oe  = {PW{~a_in}};
  assign pb_oe  = {PW{~b_in}};
  assign pc_oe  = {{(PW-HW){~cu_in}}, {HW{~cl_in}}};

  always_comb begin
    dout = '0;
    if (sel && rd) begin
      case (addr)
        2'd0: dout = a_in ? pa_in : a_q;
        2'd1: dout = b_in ? pb_in : b_q;
        2'd2: dout = {cu_in ? pc_in[PW-1:HW] : c_q[PW-1:HW],
                      cl_in ? pc_in[HW-1:0]  : c_q[HW-1:0]};
        default: dout = PW'({1'b1, 2'b00, a_in, cu_in, 1'b0, b_in, cl_in});
      endcase
    end
  end

  a_r4_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

  a_r5_bad_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr == 2'd3 && !din[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) && $stable(pa_out)));

  a_r6_porta_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr == 2'd0) |=> pa_out == $past(din));

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
              $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  a_r7_input_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd && addr == 2'd1 && pb_oe == '0) |-> dout == pb_in);

  a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd) |-> dout == '0);
endmodule

// File: tb/sim_pario3.sv
module sim_pario3;
  logic clk = 0, rst_n = 0, sel = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  pario3 u0 (.clk, .rst_n, .sel, .addr, .rd, .wr, .din, .dout,
             .pa_in, .pa_out, .pa_oe, .pb_in, .pb_out, .pb_oe,
             .pc_in, .pc_out, .pc_oe);

  always #5 clk = ~clk;

  // ctl, wa, wb, wc, ia, ib, ic, ra, rb, rc
  localparam logic [79:0] VEC [5] = '{
    {8'h83, 8'h5A, 8'h11, 8'hC3, 8'hF0, 8'h3C, 8'hA5, 8'h5A, 8'h3C, 8'hC5},
    {8'h9B, 8'h5A, 8'h11, 8'hC3, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56},
    {8'h80, 8'hAA, 8'h55, 8'h3C, 8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'h55, 8'h3C},
    {8'h8A, 8'h01, 8'h02, 8'h97, 8'h00, 8'hE7, 8'h6B, 8'h01, 8'hE7, 8'h67},
    {8'h91, 8'h77, 8'h88, 8'h4D, 8'h9C, 8'h00, 8'hE2, 8'h9C, 8'h88, 8'h42}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic s = 1);
    @(negedge clk);
    sel = s; wr = 1; addr = a; din = d;
    @(negedge clk);
    sel = 0; wr = 0; din = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1; rd = 1; addr = a;
    #1 d = dout;
    sel = 0; rd = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pa_oe | pb_oe | pc_oe, 8'h00, "R2 enables");
    chk(pa_out | pb_out | pc_out, 8'h00, "R2 latches");
    bus_rd(2'd3, r); chk(r, 8'h9B, "R2 R10 ctl readback");

    for (int i = 0; i < 5; i++) begin
      logic [7:0] c, wa, wb, wc, ia, ib, ic, ra, rb, rc;
      {c, wa, wb, wc, ia, ib, ic, ra, rb, rc} = VEC[i];
      bus_wr(2'd3, c);
      bus_wr(2'd0, wa); bus_wr(2'd1, wb); bus_wr(2'd2, wc);
      pa_in = ia; pb_in = ib; pc_in = ic;
      bus_rd(2'd0, r); chk(r, ra, "R1 R7 R8 port A read");
      bus_rd(2'd1, r); chk(r, rb, "R1 R7 R8 port B read");
      bus_rd(2'd2, r); chk(r, rc, "R1 R9 port C read");
      bus_rd(2'd3, r); chk(r, c & 8'h9B, "R10 ctl readback");
      chk(pa_oe, {8{~c[4]}}, "R3 A enable");
      chk(pb_oe, {8{~c[1]}}, "R3 B enable");
      chk(pc_oe, {{4{~c[3]}}, {4{~c[0]}}}, "R3 C enable");
      chk(pa_out, wa, "R6 A latch");
      chk(pc_out, wc, "R6 C latch");
    end

    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'hFF); bus_wr(2'd1, 8'hEE); bus_wr(2'd2, 8'hDD);
    repeat (4) @(negedge clk);
    chk(pa_out, 8'hFF, "R6 hold A");
    chk(pb_out, 8'hEE, "R6 hold B");
    bus_wr(2'd3, 8'h05);
    chk(pa_oe, 8'hFF, "R5 A enable kept");
    chk(pc_oe, 8'hFF, "R5 C enable kept");
    chk(pa_out, 8'hFF, "R5 latch kept");
    bus_rd(2'd3, r); chk(r, 8'h80, "R5 ctl readback kept");
    bus_wr(2'd0, 8'h3E, 1'b0);
    chk(pa_out, 8'hFF, "R12 unselected write");
    @(negedge clk);
    sel = 1; addr = 2'd0; rd = 0;
    #1 chk(dout, 8'h00, "R11 rd low");
    sel = 0; rd = 1;
    #1 chk(dout, 8'h00, "R11 sel low");
    rd = 0;
    bus_wr(2'd3, 8'h80);
    chk(pa_out, 8'h00, "R4 A cleared");
    chk(pb_out, 8'h00, "R4 B cleared");
    chk(pc_out, 8'h00, "R4 C cleared");
    bus_rd(2'd0, r); chk(r, 8'h00, "R4 R8 A read after clear");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule